// File: doc/BRIEF.md
# Cycle-Stealing DMA Sequencer with Switch-Load Mode

This block sequences direct memory transfers for an 8-bit processor whose machine cycle lasts a fixed eight clocks. Two active-low request lines, one for bus-to-memory and one for memory-to-bus, are looked at on the last clock of every machine cycle. If either is pending, the following machine cycle is taken away from the processor and used for one transfer. The processor program needs no handshake.

The address of every transfer comes from a 16-bit pointer that stands in for general register zero of the processor. The pointer steps by one at the end of each stolen cycle, so repeated requests walk through memory. When both the clear and the wait controls are held, the sequencer is in a load mode. No program runs, only bus-to-memory requests are honoured, and a byte from front-panel switches can be strobed into each consecutive address with no bootstrap ROM.

Top module: `cyclesteal_dma`

## Requirements
- R1: `mc_phase` counts 0,1,...,7 and wraps to 0, one step per clock; each pass through the eight values is one machine cycle.
- R2: Requests are sampled only at the clock edge that ends phase 7, as a low level on `dma_in_n` or `dma_out_n`; a granted transfer occupies the whole next machine cycle, and the cycle kind never changes inside a machine cycle.
- R3: When both request lines are low at the same sampling edge, the bus-to-memory transfer is granted.
- R4: At most one transfer is granted per machine-cycle boundary; a request held low across several boundaries receives back-to-back stolen cycles with no processor cycle between them.
- R5: `dma_ack` is high for exactly the eight clocks of every stolen cycle, rising in phase 0, and low otherwise.
- R6: `mem_addr` shows the pointer; the pointer increases by one at the edge that ends each stolen cycle and holds its value at all other edges.
- R7: In a bus-to-memory cycle `mem_wr` is high only in phases 6 and 7, and `mem_wdata` carries `bus_in`.
- R8: In a memory-to-bus cycle `mem_rd` is high for all eight clocks, `dev_data` carries `mem_rdata`, and `dev_stb` is high only in phases 6 and 7.
- R9: Load mode is in force for a machine cycle when `clr_in` and `wait_in` were both high at the sampling edge that starts it; in load mode a memory-to-bus request is ignored (no ack, no strobe, pointer unchanged) while bus-to-memory requests fill consecutive addresses. Either control alone does not enter load mode.
- R10: `cpu_slot` is high only in machine cycles that are neither stolen nor in load mode.
- R11: Synchronous `rst` sets the phase to 0, the pointer to 0 and the cycle kind to processor, and a request present during reset is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_in_n | input | 1 | Bus-to-memory request, active low |
| dma_out_n | input | 1 | Memory-to-bus request, active low |
| clr_in | input | 1 | Processor clear control, active high |
| wait_in | input | 1 | Processor wait control, active high |
| bus_in | input | 8 | Byte offered by the device for a bus-to-memory transfer |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| mc_phase | output | 3 | Clock index inside the machine cycle |
| dma_ack | output | 1 | High for the whole of a stolen cycle |
| mem_addr | output | 16 | Transfer pointer |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte to write into memory |
| mem_rd | output | 1 | Memory read enable |
| dev_data | output | 8 | Byte handed to the device |
| dev_stb | output | 1 | Device capture strobe |
| cpu_slot | output | 1 | Machine cycle belongs to a running program |

## Verification
Two demands can meet at one boundary: both request lines low together, and a held request meeting the start of load mode or a reset. The bench provokes the first by pulling both lines low at the same phase-7 sampling point, twice in a row. It then judges that the write strobe, the device strobe and the pointer step match bus-to-memory service in both cycles, with no processor slot between them. It also holds a memory-to-bus request inside load mode and checks that no acknowledge appears and that the pointer stays where the next bus-to-memory fill expects it.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    typedef enum logic [1:0] {
        MC_CPU  = 2'd0,
        MC_DIN  = 2'd1,
        MC_DOUT = 2'd2
    } mc_kind_e;

    typedef struct packed {
        logic in_req;
        logic out_req;
        logic load;
    } req_sample_t;

    function automatic mc_kind_e pick_kind(req_sample_t s);
        if (s.in_req)
            return MC_DIN;
        if (s.out_req && !s.load)
            return MC_DOUT;
        return MC_CPU;
    endfunction

    function automatic logic is_stolen(mc_kind_e k);
        return k != MC_CPU;
    endfunction

endpackage

// File: rtl/mc_timer.sv
module mc_timer #(
    parameter int PH_BITS = 3
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PH_BITS-1:0] phase,
    output logic               boundary
);
    localparam logic [PH_BITS-1:0] LAST_PH = {PH_BITS{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign boundary = (phase == LAST_PH);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $past(boundary) |-> phase == '0);

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(boundary) && !$past(rst)) |-> phase == $past(phase) + 1'b1);

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import cs_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     boundary,
    input  logic     dma_in_n,
    input  logic     dma_out_n,
    input  logic     clr_in,
    input  logic     wait_in,
    output mc_kind_e kind,
    output logic     load_q
);
    req_sample_t smp;

    always_comb begin
        smp.in_req  = !dma_in_n;
        smp.out_req = !dma_out_n;
        smp.load    = clr_in && wait_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind   <= MC_CPU;
            load_q <= 1'b0;
        end else if (boundary) begin
            kind   <= pick_kind(smp);
            load_q <= smp.load;
        end
    end

    // R2
    kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(boundary) && !$past(rst)) |-> $stable(kind));

    // R3
    in_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(boundary) && !$past(rst) && !$past(dma_in_n)) |-> kind == MC_DIN);

    // R9
    load_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        load_q |-> kind != MC_DOUT);

endmodule

// File: rtl/r0_pointer.sv
module r0_pointer #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  logic          stolen,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (boundary && stolen)
            ptr <= ptr + 1'b1;
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(boundary) && $past(stolen))) |-> $stable(ptr));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(boundary) && $past(stolen)) |-> ptr == $past(ptr) + 1'b1);

endmodule

// File: rtl/cyclesteal_dma.sv
module cyclesteal_dma
    import cs_dma_pkg::*;
#(
    parameter int PH_BITS = 3,
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int STB_CLKS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dma_in_n,
    input  logic               dma_out_n,
    input  logic               clr_in,
    input  logic               wait_in,
    input  logic [DW-1:0]      bus_in,
    input  logic [DW-1:0]      mem_rdata,
    output logic [PH_BITS-1:0] mc_phase,
    output logic               dma_ack,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_wr,
    output logic [DW-1:0]      mem_wdata,
    output logic               mem_rd,
    output logic [DW-1:0]      dev_data,
    output logic               dev_stb,
    output logic               cpu_slot
);
    localparam int CYC_LEN  = 1 << PH_BITS;
    localparam int STB_FROM = CYC_LEN - STB_CLKS;

    logic     boundary;
    logic     load_q;
    logic     stolen;
    logic     late_win;
    mc_kind_e kind;

    mc_timer #(.PH_BITS(PH_BITS)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .phase    (mc_phase),
        .boundary (boundary)
    );

    slot_arbiter arb_i (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .dma_in_n  (dma_in_n),
        .dma_out_n (dma_out_n),
        .clr_in    (clr_in),
        .wait_in   (wait_in),
        .kind      (kind),
        .load_q    (load_q)
    );

    assign stolen = is_stolen(kind);

    r0_pointer #(.AW(AW)) ptr_i (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .stolen   (stolen),
        .ptr      (mem_addr)
    );

    always_comb begin
        late_win  = int'(mc_phase) >= STB_FROM;
        dma_ack   = stolen;
        mem_wr    = (kind == MC_DIN) && late_win;
        mem_wdata = (kind == MC_DIN) ? bus_in : '0;
        mem_rd    = (kind == MC_DOUT);
        dev_data  = (kind == MC_DOUT) ? mem_rdata : '0;
        dev_stb   = (kind == MC_DOUT) && late_win;
        cpu_slot  = !stolen && !load_q;
    end

    // R5
    ack_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_ack) |-> mc_phase == '0);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr, dev_stb}));

    // R10
    slot_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_slot && dma_ack));

    // R8
    rd_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mc_phase != '0) |-> $past(mem_rd));

endmodule

// File: tb/cyclesteal_dma_tb_top.sv
module cyclesteal_dma_tb_top;

    typedef struct packed {
        logic       in_rq;
        logic       out_rq;
        logic       clr;
        logic       wt;
        logic [7:0] bus;
        logic [7:0] rd;
        logic [1:0] ek;   // 0 processor, 1 bus-to-memory, 2 memory-to-bus
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 2'd0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h00, 2'd1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA5, 2'd2},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h77, 2'd1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h77, 2'd1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h81, 2'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h12, 8'h00, 2'd1},
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h99, 2'd0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h34, 8'h00, 2'd1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h56, 8'hEE, 2'd1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h4D, 2'd2},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h6E, 2'd2},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dma_in_n = 1'b1;
    logic       dma_out_n = 1'b1;
    logic       clr_in = 1'b0;
    logic       wait_in = 1'b0;
    logic [7:0] bus_in = '0;
    logic [7:0] mem_rdata = '0;
    logic [2:0] mc_phase;
    logic       dma_ack;
    logic [15:0] mem_addr;
    logic       mem_wr;
    logic [7:0] mem_wdata;
    logic       mem_rd;
    logic [7:0] dev_data;
    logic       dev_stb;
    logic       cpu_slot;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_ptr = '0;

    always #5 clk = ~clk;

    cyclesteal_dma dut_i (
        .clk(clk), .rst(rst), .dma_in_n(dma_in_n), .dma_out_n(dma_out_n),
        .clr_in(clr_in), .wait_in(wait_in), .bus_in(bus_in), .mem_rdata(mem_rdata),
        .mc_phase(mc_phase), .dma_ack(dma_ack), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .dev_data(dev_data), .dev_stb(dev_stb),
        .cpu_slot(cpu_slot)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sync_ph7();
        do @(negedge clk); while (mc_phase != 3'd7);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mc_phase == 3'd0, "R11 phase at reset", 32'(mc_phase), 0);
        chk(mem_addr == 16'd0, "R11 pointer at reset", 32'(mem_addr), 0);
        chk(!dma_ack && cpu_slot, "R11 processor cycle at reset", {dma_ack, cpu_slot}, 32'b01);
        rst = 1'b0;
        sync_ph7();

        for (int v = 0; v < NV; v++) begin
            vec_t t = TBL[v];
            logic ld = t.clr && t.wt;
            dma_in_n  = !t.in_rq;
            dma_out_n = !t.out_rq;
            clr_in    = t.clr;
            wait_in   = t.wt;
            bus_in    = t.bus;
            mem_rdata = t.rd;
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                // R1 phase sequence
                chk(mc_phase == 3'(p), "R1 phase", 32'(mc_phase), p);
                if (p == 0) begin
                    // R2 R3 R4 R9 kind of the granted cycle; R5 ack
                    chk(dma_ack == (t.ek != 0), "R5 R2 R3 R4 R9 ack", 32'(dma_ack), 32'(t.ek != 0));
                    // R6 address
                    chk(mem_addr == exp_ptr, "R6 address", 32'(mem_addr), 32'(exp_ptr));
                    // R10 slot
                    chk(cpu_slot == (t.ek == 0 && !ld), "R10 cpu slot", 32'(cpu_slot), 32'(t.ek == 0 && !ld));
                end
                if (p == 3) begin
                    // R8 read enable, R5 ack held
                    chk(mem_rd == (t.ek == 2), "R8 read enable", 32'(mem_rd), 32'(t.ek == 2));
                    chk(dma_ack == (t.ek != 0), "R5 ack mid cycle", 32'(dma_ack), 32'(t.ek != 0));
                end
                if (p == 5)
                    // R7 R8 no strobe early
                    chk(!mem_wr && !dev_stb, "R7 R8 early strobe", {mem_wr, dev_stb}, 0);
                if (p == 6 || p == 7) begin
                    chk(mem_wr == (t.ek == 1), "R7 write strobe", 32'(mem_wr), 32'(t.ek == 1));
                    chk(dev_stb == (t.ek == 2), "R8 device strobe", 32'(dev_stb), 32'(t.ek == 2));
                    if (t.ek == 1)
                        chk(mem_wdata == t.bus, "R7 write data", 32'(mem_wdata), 32'(t.bus));
                    if (t.ek == 2)
                        chk(dev_data == t.rd, "R8 device data", 32'(dev_data), 32'(t.rd));
                end
            end
            if (t.ek != 0)
                exp_ptr = exp_ptr + 16'd1;
        end

        // R11 reset mid-run with a request pending
        dma_in_n = 1'b0;
        clr_in = 1'b0;
        wait_in = 1'b0;
        bus_in = 8'h9D;
        rst = 1'b1;
        @(negedge clk);
        chk(mc_phase == 3'd0, "R11 phase after reset", 32'(mc_phase), 0);
        chk(mem_addr == 16'd0, "R11 pointer cleared", 32'(mem_addr), 0);
        chk(!dma_ack, "R11 request not granted in reset", 32'(dma_ack), 0);
        rst = 1'b0;
        sync_ph7();
        @(negedge clk);
        chk(dma_ack && mem_addr == 16'd0, "R6 R11 first transfer at zero", {dma_ack, mem_addr}, 32'h10000);
        repeat (6) @(negedge clk);
        chk(mem_wr && mem_wdata == 8'h9D, "R7 write after reset", {mem_wr, mem_wdata}, 32'h19D);
        dma_in_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!dma_ack && mem_addr == 16'd1, "R6 pointer stepped after reset", {dma_ack, mem_addr}, 32'h00001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule